// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 32-bit virtual addresses into 30-bit physical addresses for a system that uses 4 KB pages. It keeps sixteen recently used translations. Each request is compared against every stored translation at once. On a hit, the block joins the stored physical page number with the untranslated low 12 address bits. On a miss, the block raises a one-cycle request that carries the virtual page number. An external agent then walks the page table and answers with a refill. The refill either supplies a translation or says that the page is not resident, which the block reports as a page fault. After a refill the requester retries the access.

Each stored translation has a valid flag, a dirty flag and a reference flag. The hardware sets the reference flag on every hit and sets the dirty flag on every store hit. When a refill arrives, the reference flags pick the entry to overwrite, which approximates least-recently-used replacement. A single-cycle flush input empties the whole buffer.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, no entry is valid. Every lookup misses, and `rsp_valid_o`, `miss_o` and `fault_o` are 0 until a request or refill arrives.
- R2: A request accepted on one clock edge gives its result on the next edge, with `rsp_valid_o` high for exactly that cycle. On a hit, `rsp_paddr_o[29:12]` is the stored physical page number and `rsp_paddr_o[11:0]` equals `req_vaddr_i[11:0]`. The virtual page number is `req_vaddr_i[31:12]`.
- R3: A lookup that matches no valid entry returns `rsp_hit_o`=0. In the same cycle it returns `miss_o`=1 with `miss_vpn_o` equal to the requested virtual page number. `miss_o` is never high together with `rsp_hit_o`.
- R4: A refill with `refill_present_i`=1 installs `refill_vpn_i`/`refill_ppn_i` into one entry at the refill edge. A retried lookup in a later cycle then hits with the refilled page number.
- R5: A refill with `refill_present_i`=0 installs nothing. It pulses `fault_o` high on the next cycle. Lookups of that page keep missing, and no existing translation is displaced.
- R6: A store hit (`req_store_i`=1) sets the entry's dirty flag. `rsp_dirty_o` on a hit shows the dirty flag as it stands after that access. A newly installed entry is clean.
- R7: Every hit sets the entry's reference flag. A newly installed entry has its reference flag clear.
- R8: If any entry is invalid, a refill overwrites the lowest-numbered invalid entry.
- R9: If all entries are valid, a refill overwrites the lowest-numbered entry whose reference flag is clear. If every reference flag is set, all reference flags are cleared and entry 0 is overwritten.
- R10: `flush_i` invalidates every entry on one edge and takes priority over a refill in the same cycle. After a flush, every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_store_i | input | 1 | Request is a store |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_paddr_o | output | 30 | Translated physical address (0 on miss) |
| rsp_dirty_o | output | 1 | Dirty flag of the hit entry after the access |
| miss_o | output | 1 | Refill request pulse |
| miss_vpn_o | output | 20 | Virtual page number to refill |
| refill_valid_i | input | 1 | Refill answer strobe |
| refill_vpn_i | input | 20 | Virtual page number of the answer |
| refill_ppn_i | input | 18 | Physical page number of the answer |
| refill_present_i | input | 1 | Page resident (0 means page fault) |
| fault_o | output | 1 | Page fault pulse |

## Verification
Every result is one register stage deep. The hit flag, physical address, dirty flag and refill request belong to the cycle after the request, and the fault pulse belongs to the cycle after the refill answer. The bench drives each request or answer at a falling edge, holds it across exactly one rising edge, and samples the outputs at the next falling edge. At that point the registered outputs are stable and the strobes have not yet been withdrawn. Replacement order cannot be seen directly. The bench infers it from which earlier translation starts to miss after a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 30;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [PA_W-1:0] join_phys(input logic [PPN_W-1:0] ppn,
                                                input logic [VA_W-1:0]  va);
    return {ppn, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_i,
  input  logic [VPN_W-1:0] tab_vpn_i [N],
  input  logic [VPN_W-1:0] vpn_i,
  output logic [N-1:0]     match_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tab_vpn_i[g] == vpn_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (match_o[i]) idx_o = idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     ref_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             wrap_o
);
  logic             any_free, any_cold;
  logic [IDX_W-1:0] free_idx, cold_idx;

  always_comb begin
    any_free = 1'b0;
    any_cold = 1'b0;
    free_idx = '0;
    cold_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (!ref_i[i]) begin
        any_cold = 1'b1;
        cold_idx = IDX_W'(i);
      end
    end
  end

  assign wrap_o = !any_free && !any_cold;
  assign idx_o  = any_free ? free_idx : (any_cold ? cold_idx : '0);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_store_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_dirty_o,
  output logic             miss_o,
  output logic [VPN_W-1:0] miss_vpn_o,
  input  logic             refill_valid_i,
  input  logic [VPN_W-1:0] refill_vpn_i,
  input  logic [PPN_W-1:0] refill_ppn_i,
  input  logic             refill_present_i,
  output logic             fault_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, ref_q, dirty_q;
  logic [ENTRIES-1:0] valid_d, ref_d, dirty_d;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  // named internal events
  logic [ENTRIES-1:0] match_vec;
  logic               lookup_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic               ref_wrap;
  logic               access_hit;
  logic               install;
  logic               raise_fault;

  tlb_match #(.N(ENTRIES), .IDX_W(IDX_W)) u_match (
    .valid_i   (valid_q),
    .tab_vpn_i (vpn_q),
    .vpn_i     (page_of(req_vaddr_i)),
    .match_o   (match_vec),
    .hit_o     (lookup_hit),
    .idx_o     (hit_idx)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_i (valid_q),
    .ref_i   (ref_q),
    .idx_o   (victim_idx),
    .wrap_o  (ref_wrap)
  );

  assign access_hit  = req_valid_i && lookup_hit;
  assign install     = refill_valid_i && refill_present_i && !flush_i;
  assign raise_fault = refill_valid_i && !refill_present_i;

  always_comb begin
    valid_d = valid_q;
    ref_d   = ref_q;
    dirty_d = dirty_q;
    if (access_hit) begin
      ref_d[hit_idx] = 1'b1;
      if (req_store_i) dirty_d[hit_idx] = 1'b1;
    end
    if (install) begin
      if (ref_wrap) ref_d = '0;
      ref_d[victim_idx]   = 1'b0;
      dirty_d[victim_idx] = 1'b0;
      valid_d[victim_idx] = 1'b1;
    end
    if (flush_i) begin
      valid_d = '0;
      ref_d   = '0;
      dirty_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      vpn_q[victim_idx] <= refill_vpn_i;
      ppn_q[victim_idx] <= refill_ppn_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_dirty_o <= 1'b0;
      miss_o      <= 1'b0;
      miss_vpn_o  <= '0;
      fault_o     <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= access_hit;
      rsp_paddr_o <= access_hit ? join_phys(ppn_q[hit_idx], req_vaddr_i) : '0;
      rsp_dirty_o <= access_hit && (dirty_q[hit_idx] || req_store_i);
      miss_o      <= req_valid_i && !lookup_hit;
      miss_vpn_o  <= page_of(req_vaddr_i);
      fault_o     <= raise_fault;
    end
  end

  // assertions
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);
  assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o);
  assert_offset_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> (!rsp_hit_o || rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0])));
  assert_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit_o && miss_o));
  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raise_fault |=> fault_o);
  assert_fault_no_install_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_fault && !access_hit && !flush_i) |=> $stable(valid_q));
  assert_store_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (access_hit && req_store_i) |=> rsp_dirty_o);
  assert_victim_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_q) |-> !valid_q[victim_idx]);
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));
endmodule

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_store_i = 1'b0;
  logic        rsp_valid_o, rsp_hit_o, rsp_dirty_o, miss_o, fault_o;
  logic [29:0] rsp_paddr_o;
  logic [19:0] miss_vpn_o;
  logic        refill_valid_i = 1'b0;
  logic [19:0] refill_vpn_i = '0;
  logic [17:0] refill_ppn_i = '0;
  logic        refill_present_i = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlb_xlate dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_store_i(req_store_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_paddr_o(rsp_paddr_o),
    .rsp_dirty_o(rsp_dirty_o), .miss_o(miss_o), .miss_vpn_o(miss_vpn_o),
    .refill_valid_i(refill_valid_i), .refill_vpn_i(refill_vpn_i),
    .refill_ppn_i(refill_ppn_i), .refill_present_i(refill_present_i),
    .fault_o(fault_o)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        st;
    logic [29:0] pa;
    logic        dirty;
  } vec_t;

  // entry i holds page 0x10000+i -> frame 0x2A000+i
  localparam vec_t VECS [6] = '{
    '{32'h1000_5ABC, 1'b0, 30'h2A00_5ABC, 1'b0},
    '{32'h1000_5004, 1'b1, 30'h2A00_5004, 1'b1},
    '{32'h1000_5FFF, 1'b0, 30'h2A00_5FFF, 1'b1},
    '{32'h1000_F000, 1'b0, 30'h2A00_F000, 1'b0},
    '{32'h1000_0FFF, 1'b1, 30'h2A00_0FFF, 1'b1},
    '{32'h1000_A777, 1'b0, 30'h2A00_A777, 1'b0}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input bit st, input bit eh,
                        input logic [29:0] epa, input bit ed, input string rq);
    @(negedge clk);
    req_valid_i = 1'b1; req_vaddr_i = va; req_store_i = st;
    @(negedge clk);
    req_valid_i = 1'b0; req_store_i = 1'b0;
    chk(rsp_valid_o == 1'b1, rq, "rsp_valid", 32'(rsp_valid_o), 32'd1);
    chk(rsp_hit_o == eh, rq, "hit", 32'(rsp_hit_o), 32'(eh));
    if (eh) begin
      chk(rsp_paddr_o == epa, rq, "paddr", 32'(rsp_paddr_o), 32'(epa));
      chk(rsp_dirty_o == ed, rq, "dirty", 32'(rsp_dirty_o), 32'(ed));
      chk(miss_o == 1'b0, rq, "miss on hit", 32'(miss_o), 32'd0);
    end else begin
      chk(miss_o == 1'b1, rq, "miss", 32'(miss_o), 32'd1);
      chk(miss_vpn_o == va[31:12], rq, "miss_vpn", 32'(miss_vpn_o), 32'(va[31:12]));
    end
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [17:0] ppn,
                        input bit present, input string rq);
    @(negedge clk);
    refill_valid_i = 1'b1; refill_vpn_i = vpn; refill_ppn_i = ppn;
    refill_present_i = present;
    @(negedge clk);
    refill_valid_i = 1'b0;
    chk(fault_o == !present, rq, "fault", 32'(fault_o), 32'(!present));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid_o == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid_o), 32'd0);
    chk(miss_o == 1'b0, "R1", "miss in reset", 32'(miss_o), 32'd0);
    chk(fault_o == 1'b0, "R1", "fault in reset", 32'(fault_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid_o == 1'b0, "R1", "rsp_valid idle", 32'(rsp_valid_o), 32'd0);
    lookup(32'h1000_0123, 1'b0, 1'b0, '0, 1'b0, "R1 R3 cold miss");

    // R4 R8 fill every entry, retry each
    for (int i = 0; i < 16; i++) begin
      refill(20'h10000 + 20'(i), 18'h2A000 + 18'(i), 1'b1, "R4 refill");
      lookup(32'h1000_0000 + 32'(i) * 32'h1000 + 32'h0AB, 1'b0, 1'b1,
             30'h2A00_0000 + 30'(i) * 30'h1000 + 30'h0AB, 1'b0, "R4 R8 retry hit");
    end

    // R2 R6 table of translations
    for (int k = 0; k < 6; k++)
      lookup(VECS[k].va, VECS[k].st, 1'b1, VECS[k].pa, VECS[k].dirty, "R2 R6 table");

    // R9 all reference flags set: wrap, entry 0 replaced
    refill(20'h20000, 18'h3F000, 1'b1, "R9 wrap refill");
    lookup(32'h1000_0000, 1'b0, 1'b0, '0, 1'b0, "R9 entry0 evicted");
    lookup(32'h2000_0123, 1'b0, 1'b1, 30'h3F00_0123, 1'b0, "R6 R9 new entry clean");
    lookup(32'h1000_1000, 1'b0, 1'b1, 30'h2A00_1000, 1'b0, "R7 touch entry1");
    // R7 R9 entries 0,1 referenced: entry 2 is first with clear flag
    refill(20'h20001, 18'h3F001, 1'b1, "R9 second refill");
    lookup(32'h1000_2000, 1'b0, 1'b0, '0, 1'b0, "R7 R9 entry2 evicted");
    lookup(32'h1000_1000, 1'b0, 1'b1, 30'h2A00_1000, 1'b0, "R7 R9 entry1 kept");
    lookup(32'h2000_1456, 1'b0, 1'b1, 30'h3F00_1456, 1'b0, "R9 second new entry");
    lookup(32'h2000_0FFF, 1'b0, 1'b1, 30'h3F00_0FFF, 1'b0, "R9 first new entry kept");

    // R5 page fault: nothing installed, next victim (entry 3) survives
    refill(20'h30000, 18'h00111, 1'b0, "R5 fault");
    @(negedge clk);
    chk(fault_o == 1'b0, "R5", "fault is a pulse", 32'(fault_o), 32'd0);
    lookup(32'h3000_0000, 1'b0, 1'b0, '0, 1'b0, "R5 faulted page misses");
    lookup(32'h1000_3210, 1'b0, 1'b1, 30'h2A00_3210, 1'b0, "R5 entry3 survives");

    // R10 flush
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    lookup(32'h1000_1000, 1'b0, 1'b0, '0, 1'b0, "R10 flushed miss");
    lookup(32'h2000_0000, 1'b0, 1'b0, '0, 1'b0, "R10 flushed miss");
    refill(20'h40000, 18'h01234, 1'b1, "R8 refill after flush");
    lookup(32'h4000_0FED, 1'b1, 1'b1, 30'h0123_4FED, 1'b1, "R8 R6 hit after flush");
    lookup(32'h4000_0001, 1'b0, 1'b1, 30'h0123_4001, 1'b1, "R6 dirty retained");

    // R10 flush beats refill in the same cycle
    @(negedge clk);
    flush_i = 1'b1;
    refill_valid_i = 1'b1; refill_vpn_i = 20'h50000; refill_ppn_i = 18'h00555;
    refill_present_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0; refill_valid_i = 1'b0;
    lookup(32'h5000_0000, 1'b0, 1'b0, '0, 1'b0, "R10 flush priority");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule